// File: doc/BRIEF.md
# Single-Channel Byte Transfer Engine

This block is one transfer channel between a 24-bit system bus (the A side) and a byte-wide peripheral register bus (the B side). A processor sets up the channel through a small byte-wide register file. The setup gives the direction, the A-side start address and how it moves, the peripheral port, a transfer mode and a 16-bit byte count. After a `start` pulse the channel moves one byte per step until the count runs out. On each side it drives simple read and write strobes, and it keeps a running cycle cost for the transfer.

Each byte takes two clock cycles. In the fetch cycle the engine raises the read strobe of the source bus. In the put cycle it raises the write strobe of the destination bus, and the read data is expected one cycle after the read strobe. The peripheral address is a fixed page ORed with the sum of the port and a mode-dependent offset, so one transfer can cycle over a group of adjacent peripheral registers. A special case covers the work-RAM data port aimed at work RAM: no data is copied, or a fill value is written instead.

Top module: `dma_channel`

## Requirements
- R1: Registers are read (combinationally on `reg_rdata`) and written (on the clock edge with `reg_wr`) at `reg_sel` offsets 0 control, 1 port, 2 A-offset low, 3 A-offset high, 4 A bank, 5 count low, 6 count high. All reset to 0. Writes are ignored while `busy` is high.
- R2: A read or write with `reg_sel` above 6 raises `reg_err` in that same cycle, returns 0 on `reg_rdata` and changes no register.
- R3: For byte i (counted from 0 at start), `b_addr` = 0x2100 | (port + offset). The mode is control bits [2:0]. Mode 0 gives offset 0. Mode 1 gives 0,1 repeating. Mode 2 gives 0,0. Mode 3 gives 0,1,2,3 repeating. Modes 4 to 7 give 0.
- R4: Control bit 7 clear means A-to-B: read `a_addr` in the fetch cycle, then write that byte to `b_addr` in the put cycle. Set means B-to-A: read B, then write to A. At most one strobe is active at a time.
- R5: After each byte, if control bit 3 (fixed) is clear, the 16-bit A offset decrements when control bit 4 is set and increments when it is clear. It wraps within the bank. The bank byte never changes during a transfer.
- R6: The count decrements after each byte. The transfer ends after the byte that brings it to 0, and at least one byte always moves. A start count of 0 moves 65536 bytes.
- R7: When port is 0x80 and `a_is_wram` is high, no data is copied. An A-to-B step raises no strobe and costs 8. A B-to-A step writes 0xFF to `a_addr`, performs no B read and costs 4.
- R8: `xfer_cycles` is set to 8 at start and grows by 8 per normal byte. It holds its final value after the transfer.
- R9: `busy` is high from the cycle after an accepted `start` until the cycle after the last put. `done` is high for one cycle, in the last put cycle. A `start` while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 4 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| reg_err | output | 1 | Access to an unmapped offset |
| start | input | 1 | Begin a transfer |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Last byte being written |
| xfer_cycles | output | 24 | Cycle cost of current or last transfer |
| a_addr | output | 24 | A-bus address (bank, offset) |
| a_is_wram | input | 1 | A address decodes to work RAM |
| a_rd | output | 1 | A-bus read strobe |
| a_wr | output | 1 | A-bus write strobe |
| a_wdata | output | 8 | A-bus write data |
| a_rdata | input | 8 | A-bus read data, one cycle after `a_rd` |
| b_addr | output | 16 | B-bus address |
| b_rd | output | 1 | B-bus read strobe |
| b_wr | output | 1 | B-bus write strobe |
| b_wdata | output | 8 | B-bus write data |
| b_rdata | input | 8 | B-bus read data, one cycle after `b_rd` |

## Verification
The bench builds the channel with its default parameters: a 4-bit register select, a 0x2100 peripheral page, a 0x80 work-RAM port and a 24-bit cost counter. With these values, a count of zero runs the full 65536-byte transfer within the run. The A offset then wraps all the way back to its start, and the cost reaches 0x80008 without overflowing. The 4-bit select also reaches unmapped offsets well above 6.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int unsigned AOFF_W = 16;
  localparam int unsigned BANK_W = 8;
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned LAST_REG = 6;

  typedef struct packed {
    logic       b_to_a;
    logic [1:0] spare;
    logic       step_dn;
    logic       fixed;
    logic [2:0] mode;
  } ctrl_t;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_PUT} eng_st_e;
endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
#(
  parameter int unsigned SEL_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  sel,
  input  logic              wr,
  input  logic              rd,
  input  logic [7:0]        wdata,
  input  logic              lock,
  input  logic              adv,
  output logic [7:0]        rdata,
  output logic              bad,
  output ctrl_t             ctrl,
  output logic [7:0]        port,
  output logic [BANK_W+AOFF_W-1:0] a_full,
  output logic [CNT_W-1:0]  count
);
  ctrl_t             ctrl_q, ctrl_d;
  logic [7:0]        port_q, port_d;
  logic [AOFF_W-1:0] aoff_q, aoff_d;
  logic [BANK_W-1:0] bank_q, bank_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              wr_ok;

  assign bad   = (rd || wr) && (sel > SEL_W'(LAST_REG));
  assign wr_ok = wr && !lock && !bad;

  always_comb begin
    ctrl_d = ctrl_q;
    port_d = port_q;
    aoff_d = aoff_q;
    bank_d = bank_q;
    cnt_d  = cnt_q;
    if (adv) begin
      cnt_d = cnt_q - 1'b1;
      if (!ctrl_q.fixed)
        aoff_d = ctrl_q.step_dn ? aoff_q - 1'b1 : aoff_q + 1'b1;
    end else if (wr_ok) begin
      case (sel)
        SEL_W'(0): ctrl_d = ctrl_t'(wdata);
        SEL_W'(1): port_d = wdata;
        SEL_W'(2): aoff_d[7:0]  = wdata;
        SEL_W'(3): aoff_d[15:8] = wdata;
        SEL_W'(4): bank_d = wdata;
        SEL_W'(5): cnt_d[7:0]   = wdata;
        SEL_W'(6): cnt_d[15:8]  = wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      port_q <= '0;
      aoff_q <= '0;
      bank_q <= '0;
      cnt_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      port_q <= port_d;
      aoff_q <= aoff_d;
      bank_q <= bank_d;
      cnt_q  <= cnt_d;
    end
  end

  always_comb begin
    rdata = 8'h00;
    if (!bad) begin
      case (sel)
        SEL_W'(0): rdata = ctrl_q;
        SEL_W'(1): rdata = port_q;
        SEL_W'(2): rdata = aoff_q[7:0];
        SEL_W'(3): rdata = aoff_q[15:8];
        SEL_W'(4): rdata = bank_q;
        SEL_W'(5): rdata = cnt_q[7:0];
        SEL_W'(6): rdata = cnt_q[15:8];
        default:   rdata = 8'h00;
      endcase
    end
  end

  assign ctrl   = ctrl_q;
  assign port   = port_q;
  assign a_full = {bank_q, aoff_q};
  assign count  = cnt_q;

  assert_bad_keeps_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bad && !adv) |=> ($stable(ctrl_q) && $stable(port_q) && $stable(aoff_q)
                            && $stable(bank_q) && $stable(cnt_q)));

  assert_bank_const_R5: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> $stable(bank_q));

  assert_locked_port_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && $past(lock)) |-> $stable(port_q));
endmodule

// File: rtl/dma_boff.sv
module dma_boff (
  input  logic [2:0] mode,
  input  logic [1:0] idx,
  output logic [1:0] off
);
  always_comb begin
    case (mode)
      3'd1:    off = {1'b0, idx[0]};
      3'd3:    off = idx;
      default: off = 2'd0;
    endcase
  end
endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_pkg::*;
#(
  parameter int unsigned CYC_W     = 24,
  parameter int unsigned BASE_COST = 8,
  parameter int unsigned STEP_COST = 8,
  parameter int unsigned FILL_COST = 4,
  parameter logic [7:0]  WRAM_PORT = 8'h80,
  parameter logic [7:0]  FILL_BYTE = 8'hFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  ctrl_t            ctrl,
  input  logic [7:0]       port,
  input  logic [CNT_W-1:0] count,
  input  logic             a_is_wram,
  input  logic [7:0]       a_rdata,
  input  logic [7:0]       b_rdata,
  output logic             busy,
  output logic             done,
  output logic             adv,
  output logic [1:0]       idx,
  output logic             a_rd,
  output logic             a_wr,
  output logic [7:0]       a_wdata,
  output logic             b_rd,
  output logic             b_wr,
  output logic [7:0]       b_wdata,
  output logic [CYC_W-1:0] cost
);
  eng_st_e          st_q, st_d;
  logic [1:0]       idx_q, idx_d;
  logic [CYC_W-1:0] cost_q, cost_d;
  logic             special;

  assign special = (port == WRAM_PORT) && a_is_wram;

  always_comb begin
    st_d    = st_q;
    idx_d   = idx_q;
    cost_d  = cost_q;
    a_rd    = 1'b0;
    a_wr    = 1'b0;
    b_rd    = 1'b0;
    b_wr    = 1'b0;
    a_wdata = 8'h00;
    b_wdata = 8'h00;
    adv     = 1'b0;
    done    = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d   = ST_FETCH;
          idx_d  = 2'd0;
          cost_d = CYC_W'(BASE_COST);
        end
      end
      ST_FETCH: begin
        if (!special) begin
          if (ctrl.b_to_a) b_rd = 1'b1;
          else             a_rd = 1'b1;
        end
        st_d = ST_PUT;
      end
      ST_PUT: begin
        adv   = 1'b1;
        idx_d = idx_q + 1'b1;
        if (special) begin
          if (ctrl.b_to_a) begin
            a_wr    = 1'b1;
            a_wdata = FILL_BYTE;
            cost_d  = cost_q + CYC_W'(FILL_COST);
          end else begin
            cost_d  = cost_q + CYC_W'(STEP_COST);
          end
        end else begin
          if (ctrl.b_to_a) begin
            a_wr    = 1'b1;
            a_wdata = b_rdata;
          end else begin
            b_wr    = 1'b1;
            b_wdata = a_rdata;
          end
          cost_d = cost_q + CYC_W'(STEP_COST);
        end
        if (count == CNT_W'(1)) begin
          st_d = ST_IDLE;
          done = 1'b1;
        end else begin
          st_d = ST_FETCH;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      cost_q <= '0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      cost_q <= cost_d;
    end
  end

  assign busy = (st_q != ST_IDLE);
  assign idx  = idx_q;
  assign cost = cost_q;

  assert_one_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({a_rd, a_wr, b_rd, b_wr}));

  assert_dir_ab_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ctrl.b_to_a) |-> (!a_wr && !b_rd));

  assert_wram_no_b_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && special) |-> (!b_rd && !b_wr && !a_rd));

  assert_cost_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PUT) |=> ((cost_q - $past(cost_q) == CYC_W'(STEP_COST)) ||
                          (cost_q - $past(cost_q) == CYC_W'(FILL_COST))));

  assert_done_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
endmodule

// File: rtl/dma_channel.sv
module dma_channel
  import dma_pkg::*;
#(
  parameter int unsigned SEL_W     = 4,
  parameter int unsigned CYC_W     = 24,
  parameter logic [15:0] B_PAGE    = 16'h2100,
  parameter logic [7:0]  WRAM_PORT = 8'h80
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] reg_sel,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  output logic             reg_err,
  input  logic             start,
  output logic             busy,
  output logic             done,
  output logic [CYC_W-1:0] xfer_cycles,
  output logic [23:0]      a_addr,
  input  logic             a_is_wram,
  output logic             a_rd,
  output logic             a_wr,
  output logic [7:0]       a_wdata,
  input  logic [7:0]       a_rdata,
  output logic [15:0]      b_addr,
  output logic             b_rd,
  output logic             b_wr,
  output logic [7:0]       b_wdata,
  input  logic [7:0]       b_rdata
);
  ctrl_t            ctrl;
  logic [7:0]       port;
  logic [CNT_W-1:0] count;
  logic             adv;
  logic [1:0]       idx;
  logic [1:0]       off;

  dma_regs #(.SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .sel(reg_sel), .wr(reg_wr), .rd(reg_rd),
    .wdata(reg_wdata), .lock(busy), .adv(adv), .rdata(reg_rdata), .bad(reg_err),
    .ctrl(ctrl), .port(port), .a_full(a_addr), .count(count)
  );

  dma_boff u_boff (.mode(ctrl.mode), .idx(idx), .off(off));

  dma_engine #(.CYC_W(CYC_W), .WRAM_PORT(WRAM_PORT)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(start), .ctrl(ctrl), .port(port),
    .count(count), .a_is_wram(a_is_wram), .a_rdata(a_rdata), .b_rdata(b_rdata),
    .busy(busy), .done(done), .adv(adv), .idx(idx),
    .a_rd(a_rd), .a_wr(a_wr), .a_wdata(a_wdata),
    .b_rd(b_rd), .b_wr(b_wr), .b_wdata(b_wdata), .cost(xfer_cycles)
  );

  assign b_addr = B_PAGE | ({8'h00, port} + {14'h0000, off});
endmodule

// File: tb/sim_dma_channel.sv
module sim_dma_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  reg_sel = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        reg_err;
  logic        start = 1'b0;
  logic        busy, done;
  logic [23:0] xfer_cycles;
  logic [23:0] a_addr;
  logic        a_is_wram;
  logic        a_rd, a_wr, b_rd, b_wr;
  logic [7:0]  a_wdata, b_wdata;
  logic [7:0]  a_rdata = '0, b_rdata = '0;
  logic [15:0] b_addr;

  int vectors = 0, miscompares = 0, cyc = 0;
  int nbw = 0, naw = 0, nar = 0, nbr = 0;
  logic [15:0] bw_a [64];
  logic [7:0]  bw_d [64];
  logic [23:0] aw_a [64];
  logic [7:0]  aw_d [64];

  always #2.5 clk = ~clk;

  assign a_is_wram = (a_addr[23:16] == 8'h7E);

  dma_channel u0 (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_err(reg_err),
    .start(start), .busy(busy), .done(done), .xfer_cycles(xfer_cycles),
    .a_addr(a_addr), .a_is_wram(a_is_wram), .a_rd(a_rd), .a_wr(a_wr),
    .a_wdata(a_wdata), .a_rdata(a_rdata), .b_addr(b_addr), .b_rd(b_rd),
    .b_wr(b_wr), .b_wdata(b_wdata), .b_rdata(b_rdata)
  );

  function automatic logic [7:0] fa(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
  endfunction
  function automatic logic [7:0] fb(input logic [15:0] b);
    return b[7:0] ^ 8'hC3;
  endfunction

  always @(posedge clk) begin
    if (a_rd) begin a_rdata <= fa(a_addr); nar = nar + 1; end
    if (b_rd) begin b_rdata <= fb(b_addr); nbr = nbr + 1; end
    if (b_wr) begin
      if (nbw < 64) begin bw_a[nbw] = b_addr; bw_d[nbw] = b_wdata; end
      nbw = nbw + 1;
    end
    if (a_wr) begin
      if (naw < 64) begin aw_a[naw] = a_addr; aw_d[naw] = a_wdata; end
      naw = naw + 1;
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > 195000) begin
      miscompares = miscompares + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      summary();
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    vectors = vectors + 1;
    if (!ok) begin
      miscompares = miscompares + 1;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [3:0] s, input logic [7:0] d);
    @(negedge clk); reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [3:0] s, output logic [7:0] d, output logic e);
    @(negedge clk); reg_sel = s; reg_rd = 1'b1;
    #1; d = reg_rdata; e = reg_err;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic setup(input logic [7:0] c, input logic [7:0] p, input logic [23:0] a,
                       input logic [15:0] n);
    reg_write(4'd0, c); reg_write(4'd1, p);
    reg_write(4'd2, a[7:0]); reg_write(4'd3, a[15:8]); reg_write(4'd4, a[23:16]);
    reg_write(4'd5, n[7:0]); reg_write(4'd6, n[15:8]);
  endtask

  task automatic clear_logs();
    @(negedge clk); nbw = 0; naw = 0; nar = 0; nbr = 0;
  endtask

  task automatic run_xfer();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (busy) @(negedge clk);
  endtask

  task automatic read_a(output logic [23:0] a);
    logic e;
    reg_read(4'd2, a[7:0], e); reg_read(4'd3, a[15:8], e); reg_read(4'd4, a[23:16], e);
  endtask

  task automatic read_cnt(output logic [15:0] n);
    logic e;
    reg_read(4'd5, n[7:0], e); reg_read(4'd6, n[15:8], e);
  endtask

  task automatic t_reset();
    logic [7:0] d; logic e;
    check(busy == 1'b0, "R9 reset busy", busy, 0);
    check(xfer_cycles == 0, "R8 reset cost", xfer_cycles, 0);
    for (int i = 0; i < 7; i++) begin
      reg_read(4'(i), d, e);
      check(d == 8'h00 && !e, "R1 reset value", d, 0);
    end
  endtask

  task automatic t_regmap();
    logic [7:0] d; logic e;
    for (int i = 0; i < 7; i++) reg_write(4'(i), 8'h11 * (i + 1) + 8'h01);
    for (int i = 0; i < 7; i++) begin
      reg_read(4'(i), d, e);
      check(d == 8'(8'h11 * (i + 1) + 8'h01), "R1 readback", d, 8'h11 * (i + 1) + 8'h01);
    end
  endtask

  task automatic t_bad_sel();
    logic [7:0] d; logic e;
    setup(8'h05, 8'h22, 24'h33_4455, 16'h6677);
    @(negedge clk); reg_sel = 4'd9; reg_wdata = 8'hEE; reg_wr = 1'b1;
    #1; check(reg_err == 1'b1, "R2 err on write", reg_err, 1);
    @(negedge clk); reg_wr = 1'b0;
    reg_read(4'd13, d, e);
    check(e == 1'b1 && d == 8'h00, "R2 err on read", {e, d}, 9'h100);
    reg_read(4'd0, d, e); check(d == 8'h05, "R2 ctrl kept", d, 8'h05);
    reg_read(4'd1, d, e); check(d == 8'h22, "R2 port kept", d, 8'h22);
    reg_read(4'd6, d, e); check(d == 8'h66, "R2 count kept", d, 8'h66);
  endtask

  task automatic t_ab_mode1();
    logic [23:0] a; logic [15:0] n;
    setup(8'h01, 8'h18, 24'h00_1234, 16'd4);
    clear_logs(); run_xfer();
    check(nbw == 4 && naw == 0, "R4 A-to-B write count", nbw, 4);
    for (int i = 0; i < 4; i++) begin
      check(bw_a[i] == 16'h2118 + 16'(i % 2), "R3 mode1 b_addr", bw_a[i], 16'h2118 + i % 2);
      check(bw_d[i] == fa(24'h00_1234 + 24'(i)), "R4 A-to-B data", bw_d[i], fa(24'h00_1234 + 24'(i)));
    end
    read_a(a); check(a == 24'h00_1238, "R5 increment", a, 24'h00_1238);
    read_cnt(n); check(n == 16'd0, "R6 count ends 0", n, 0);
    check(xfer_cycles == 24'd40, "R8 cost", xfer_cycles, 40);
  endtask

  task automatic t_ba_mode3();
    logic [23:0] a;
    setup(8'h93, 8'h40, 24'h01_0001, 16'd5);
    clear_logs(); run_xfer();
    check(naw == 5 && nbw == 0 && nar == 0, "R4 B-to-A write count", naw, 5);
    for (int i = 0; i < 5; i++) begin
      check(aw_a[i] == {8'h01, 16'h0001 - 16'(i)}, "R5 decrement wraps in bank", aw_a[i], {8'h01, 16'h0001 - 16'(i)});
      check(aw_d[i] == fb(16'h2140 + 16'(i % 4)), "R3 mode3 source", aw_d[i], fb(16'h2140 + 16'(i % 4)));
    end
    read_a(a); check(a == 24'h01_FFFC, "R5 bank constant", a, 24'h01_FFFC);
  endtask

  task automatic t_fixed_mode2();
    logic [23:0] a;
    setup(8'h1A, 8'h05, 24'h02_8000, 16'd3);
    clear_logs(); run_xfer();
    for (int i = 0; i < 3; i++)
      check(bw_a[i] == 16'h2105 && bw_d[i] == fa(24'h02_8000), "R3 mode2 fixed addr", bw_a[i], 16'h2105);
    read_a(a); check(a == 24'h02_8000, "R5 fixed", a, 24'h02_8000);
  endtask

  task automatic t_mode5();
    setup(8'h05, 8'hFE, 24'h00_0010, 16'd3);
    clear_logs(); run_xfer();
    for (int i = 0; i < 3; i++)
      check(bw_a[i] == 16'h21FE, "R3 mode5 offset 0", bw_a[i], 16'h21FE);
  endtask

  task automatic t_wram();
    logic [15:0] n;
    setup(8'h00, 8'h80, 24'h7E_0100, 16'd2);
    clear_logs(); run_xfer();
    check(nbw + naw + nar + nbr == 0, "R7 A-to-B no access", nbw + naw + nar + nbr, 0);
    check(xfer_cycles == 24'd24, "R7 A-to-B cost", xfer_cycles, 24);
    read_cnt(n); check(n == 0, "R7 count ran out", n, 0);
    setup(8'h80, 8'h80, 24'h7E_0200, 16'd3);
    clear_logs(); run_xfer();
    check(naw == 3 && nbr == 0, "R7 B-to-A fill count", naw, 3);
    for (int i = 0; i < 3; i++)
      check(aw_d[i] == 8'hFF && aw_a[i] == 24'h7E_0200 + 24'(i), "R7 fill", aw_d[i], 8'hFF);
    check(xfer_cycles == 24'd20, "R7 B-to-A cost", xfer_cycles, 20);
    setup(8'h00, 8'h80, 24'h00_0300, 16'd1);
    clear_logs(); run_xfer();
    check(nbw == 1 && bw_a[0] == 16'h2180 && bw_d[0] == fa(24'h00_0300), "R7 non-wram normal", bw_a[0], 16'h2180);
  endtask

  task automatic t_timing_lock();
    logic [7:0] d; logic e;
    setup(8'h00, 8'h31, 24'h00_0000, 16'd1);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(busy && !done, "R9 busy after start", {busy, done}, 2'b10);
    @(negedge clk);
    check(busy && done, "R9 done in put", {busy, done}, 2'b11);
    @(negedge clk);
    check(!busy && !done, "R9 idle after", {busy, done}, 2'b00);
    setup(8'h00, 8'h31, 24'h00_0000, 16'd6);
    clear_logs();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    reg_write(4'd1, 8'h77);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (busy) @(negedge clk);
    reg_read(4'd1, d, e); check(d == 8'h31, "R1 write while busy ignored", d, 8'h31);
    check(nbw == 6, "R9 restart ignored", nbw, 6);
  endtask

  task automatic t_full();
    logic [23:0] a; logic [15:0] n;
    setup(8'h00, 8'h10, 24'h03_4000, 16'd0);
    clear_logs(); run_xfer();
    check(nbw == 65536, "R6 zero count moves 65536", nbw, 65536);
    check(xfer_cycles == 24'h080008, "R8 full cost", xfer_cycles, 24'h080008);
    read_a(a); check(a == 24'h03_4000, "R5 full wrap", a, 24'h03_4000);
    read_cnt(n); check(n == 0, "R6 full count", n, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regmap();
    t_bad_sel();
    t_ab_mode1();
    t_ba_mode3();
    t_fixed_mode2();
    t_mode5();
    t_wram();
    t_timing_lock();
    t_full();
    summary();
  end
endmodule